// File: doc/BRIEF.md
# DRAM Refresh Timer and Sequencer

This block runs on the controller side of an asynchronous DRAM with 256 rows. It keeps every row refreshed without help from the normal read and write path. An interval timer marks each refresh that falls due, and a small counter keeps the ones not yet serviced. While any refresh is outstanding and the sequencer is idle, the block raises a request toward the data path. When the data path grants the bus, the block takes the row strobe, both byte column strobes, the write enable, the output enable and the row-address drive for one complete refresh cycle. It then returns the bus.

The mode select picks one of three strobe encodings for each refresh:

- **CAS-before-RAS:** the memory's own row counter picks the row.
- **RAS-only:** the block presents a row from its own wrapping counter.
- **Hidden:** the data path hands over a read with its column strobes still low. The block precharges and re-opens RAS while keeping CAS and output enable low, so the read data stays on the bus.

All timing is counted in clock cycles. The defaults assume a 100 MHz clock, which gives a 3-cycle RAS pulse, a 2-cycle precharge, a 6-cycle minimum cycle and an interval of 1562 cycles.

Top module: `dram_refresh_ctl`

## Requirements
- R1: A refresh falls due every REFI_CYC clock cycles. The first one after reset release makes `ref_req` high after exactly REFI_CYC rising edges.
- R2: During and after reset, `ras_n`, `cas_hi_n`, `cas_lo_n`, `we_n` and `oe_n` are high, and `addr_oe`, `ref_busy`, `ref_req` and `ovf` are low. No strobe falls within the first RAS_PRE cycles after release.
- R3: `ref_req` is high only when the sequencer is idle and a refresh is outstanding. A refresh starts on the first rising edge at which `ref_req` and `ref_gnt` are both high. `ref_gnt` while `ref_req` is low has no effect on any output.
- R4: Mode value 0, and the spare value 3, select CAS-before-RAS:
  - both CAS strobes go low for CAS_LEAD cycles (default 1) while `ras_n` stays high;
  - then `ras_n` is low for RAS_LOW cycles (default 3) with both CAS strobes still low;
  - then every strobe is high for 2 cycles.
  - `we_n` and `oe_n` stay high, and `addr_oe` stays low.
- R5: Mode value 1 selects RAS-only:
  - `addr_oe` is high with the row on `row_addr` for 1 cycle before `ras_n` falls and for the 3 cycles it stays low;
  - both CAS strobes stay high throughout;
  - every strobe is then high for 2 cycles.
- R6: The row counter starts at 0 after reset. It steps by one when a RAS-only refresh releases `ras_n`, and wraps from 255 to 0. CAS-before-RAS and hidden refreshes leave it unchanged.
- R7: Mode value 2 selects hidden refresh:
  - both CAS strobes and `oe_n` are low for RAS_PRE cycles (default 2) with `ras_n` high;
  - then `ras_n` is low for 3 cycles with CAS and `oe_n` still low;
  - then every strobe is high for 2 cycles.
- R8: Every low pulse of `ras_n` lasts at least RAS_LOW cycles, and every high phase lasts at least RAS_PRE cycles. From one refresh start to the sequencer becoming idle again takes at least RC_CYC cycles.
- R9: Up to 8 due refreshes are held. Each started refresh consumes one, and `ref_req` falls once none are left.
- R10: A refresh falling due while 8 are already held and none is starting sets `ovf`. `ovf` stays high until reset.
- R11: The mode is sampled on the start edge. Changes of `mode_sel` during a refresh do not alter that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Refresh style: 0 CAS-before-RAS, 1 RAS-only, 2 hidden, 3 treated as 0 |
| ref_gnt | input | 1 | Bus grant from the data path |
| ref_req | output | 1 | Refresh request toward the data path |
| ref_busy | output | 1 | Block owns the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, low only in hidden refresh |
| addr_oe | output | 1 | Row address must be driven from `row_addr` |
| row_addr | output | 8 | Controller-side refresh row |
| ovf | output | 1 | Sticky missed-refresh flag |

## Verification
Each of the three strobe encodings is run, and so is the spare mode value. Comparing the strobe vector cycle by cycle tells apart which strobe leads RAS, the length of each phase, and whether output enable and the address drive belong to the chosen style. A mode change right after the start edge separates a sampled mode from a live one. A burst of backlog drained by back-to-back grants shows that one outstanding refresh is consumed per start. An ungranted run of nine intervals puts the overflow edge between the eighth and ninth tick. Finally, 257 RAS-only refreshes with a CAS-before-RAS refresh in front show both the counter wrap and that the other modes leave the row alone.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    MODE_CBR = 2'd0,
    MODE_ROW = 2'd1,
    MODE_HID = 2'd2,
    MODE_RSV = 2'd3
  } ref_mode_e;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_IDLE = 3'd1,
    ST_LEAD = 3'd2,
    ST_ACT  = 3'd3,
    ST_PRE  = 3'd4
  } seq_st_e;

  // Spare encoding falls back to the memory-counter style.
  function automatic ref_mode_e norm_mode(input logic [1:0] sel);
    return (sel == 2'd3) ? MODE_CBR : ref_mode_e'(sel);
  endfunction

  // Cycles with RAS high that open a refresh.
  function automatic int lead_len(input ref_mode_e m, input int cas_lead, input int ras_pre);
    return (m == MODE_HID) ? ras_pre : cas_lead;
  endfunction

  // Closing precharge: long enough for tRP and for the full cycle time.
  function automatic int pre_len(input int lead, input int ras_low, input int ras_pre, input int rc);
    int rest;
    rest = rc - ras_low - lead;
    return (rest > ras_pre) ? rest : ras_pre;
  endfunction

  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
  import dram_ref_pkg::*;
#(
  parameter int REFI_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = bits_for(REFI_CYC);

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(REFI_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pend_counter.sv
module pend_counter
  import dram_ref_pkg::*;
#(
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pend_nz,
  output logic ovf
);
  localparam int CW = bits_for(PEND_MAX);

  logic [CW-1:0] cnt;
  logic          full;
  logic          lost;

  assign full    = (cnt == CW'(PEND_MAX));
  assign pend_nz = (cnt != '0);
  assign lost    = tick && !take && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (tick && !take && !full) cnt <= cnt + 1'b1;
      else if (take && !tick)     cnt <= cnt - 1'b1;
      if (lost) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/row_counter.sv
module row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import dram_ref_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 3,
  parameter int RAS_PRE  = 2,
  parameter int RC_CYC   = 6,
  parameter int LANES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  output logic             idle,
  output logic             busy,
  output logic             act_end,
  output logic             ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             oe_n,
  output logic             addr_oe
);
  localparam int LEAD_STD = lead_len(MODE_CBR, CAS_LEAD, RAS_PRE);
  localparam int LEAD_HID = lead_len(MODE_HID, CAS_LEAD, RAS_PRE);
  localparam int PRE_STD  = pre_len(LEAD_STD, RAS_LOW, RAS_PRE, RC_CYC);
  localparam int PRE_HID  = pre_len(LEAD_HID, RAS_LOW, RAS_PRE, RC_CYC);
  localparam int PH_MAX   = LEAD_HID + LEAD_STD + PRE_STD + PRE_HID + RAS_LOW;
  localparam int PH_W     = bits_for(PH_MAX);

  seq_st_e   st;
  logic [PH_W-1:0] ph;
  ref_mode_e mode_q;
  ref_mode_e mode_in;
  logic      ph_last;
  logic      in_seq;
  logic      cas_on;

  assign mode_in = norm_mode(mode_sel);
  assign ph_last = (ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_INIT;
      ph     <= PH_W'(RAS_PRE - 1);
      mode_q <= MODE_CBR;
    end else begin
      case (st)
        ST_INIT: begin
          if (ph_last) st <= ST_IDLE;
          else         ph <= ph - 1'b1;
        end
        ST_IDLE: begin
          if (start) begin
            st     <= ST_LEAD;
            mode_q <= mode_in;
            ph     <= (mode_in == MODE_HID) ? PH_W'(LEAD_HID - 1) : PH_W'(LEAD_STD - 1);
          end
        end
        ST_LEAD: begin
          if (ph_last) begin
            st <= ST_ACT;
            ph <= PH_W'(RAS_LOW - 1);
          end else begin
            ph <= ph - 1'b1;
          end
        end
        ST_ACT: begin
          if (ph_last) begin
            st <= ST_PRE;
            ph <= (mode_q == MODE_HID) ? PH_W'(PRE_HID - 1) : PH_W'(PRE_STD - 1);
          end else begin
            ph <= ph - 1'b1;
          end
        end
        ST_PRE: begin
          if (ph_last) st <= ST_IDLE;
          else         ph <= ph - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st == ST_IDLE);
  assign busy    = (st == ST_LEAD) || (st == ST_ACT) || (st == ST_PRE);
  assign act_end = (st == ST_ACT) && ph_last;
  assign in_seq  = (st == ST_LEAD) || (st == ST_ACT);
  assign cas_on  = in_seq && (mode_q != MODE_ROW);

  assign ras_n   = !(st == ST_ACT);
  assign oe_n    = !(in_seq && (mode_q == MODE_HID));
  assign addr_oe = in_seq && (mode_q == MODE_ROW);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign cas_n[b] = !cas_on;
  end
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
  parameter int REFI_CYC = 1562,
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 3,
  parameter int RAS_PRE  = 2,
  parameter int RC_CYC   = 6,
  parameter int PEND_MAX = 8,
  parameter int ROW_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_busy,
  output logic             ras_n,
  output logic             cas_hi_n,
  output logic             cas_lo_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             ovf
);
  localparam int LANES = 2;

  logic             tick;
  logic             pend_nz;
  logic             seq_idle;
  logic             start;
  logic             act_end;
  logic             row_step;
  logic [LANES-1:0] cas_v;

  assign ref_req  = seq_idle && pend_nz;
  assign start    = ref_req && ref_gnt;
  assign row_step = act_end && addr_oe;
  assign cas_hi_n = cas_v[1];
  assign cas_lo_n = cas_v[0];
  assign we_n     = 1'b1;

  refresh_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pend_counter #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(start),
    .pend_nz(pend_nz), .ovf(ovf)
  );

  row_counter #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .step(row_step), .row(row_addr)
  );

  strobe_seq #(
    .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE),
    .RC_CYC(RC_CYC), .LANES(LANES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .idle(seq_idle), .busy(ref_busy), .act_end(act_end),
    .ras_n(ras_n), .cas_n(cas_v), .oe_n(oe_n), .addr_oe(addr_oe)
  );
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int RAS_LOW = 3,
  parameter int RAS_PRE = 2,
  parameter int ROW_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_hi_n,
  input logic             cas_lo_n,
  input logic             oe_n,
  input logic             addr_oe,
  input logic [ROW_W-1:0] row_addr,
  input logic             ovf,
  input logic             ref_req,
  input logic             ref_busy,
  input logic             start
);
  logic [7:0] since_rst;
  logic [7:0] lo_len;
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      lo_len    <= '0;
      hi_len    <= '0;
    end else begin
      if (since_rst != 8'hff) since_rst <= since_rst + 1'b1;
      if (!ras_n) begin
        lo_len <= (lo_len == 8'hff) ? lo_len : lo_len + 1'b1;
        hi_len <= '0;
      end else begin
        hi_len <= (hi_len == 8'hff) ? hi_len : hi_len + 1'b1;
        lo_len <= '0;
      end
    end
  end

  a_r2_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 8'(RAS_PRE)) |-> (ras_n && cas_hi_n && cas_lo_n));

  a_r3_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !ref_busy);

  a_r3_start_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ref_busy);

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_lo_n) |-> (!$past(cas_lo_n) && !$past(cas_hi_n)));

  a_r5_row_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_lo_n) |-> (addr_oe && cas_hi_n));

  a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(addr_oe)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

  a_r6_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && !$past(addr_oe)) |-> $stable(row_addr));

  a_r7_oe_under_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cas_lo_n && !cas_hi_n));

  a_r8_ras_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_len >= 8'(RAS_LOW)));

  a_r8_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_len >= 8'(RAS_PRE)));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);
endmodule

bind dram_refresh_ctl dram_refresh_chk #(
  .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_hi_n(cas_hi_n),
  .cas_lo_n(cas_lo_n), .oe_n(oe_n), .addr_oe(addr_oe),
  .row_addr(row_addr), .ovf(ovf), .ref_req(ref_req),
  .ref_busy(ref_busy), .start(start)
);

// File: tb/sim_dram_refresh_ctl.sv
module sim_dram_refresh_ctl;
  localparam int REFI = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       ref_gnt = 1'b0;
  logic       ref_req, ref_busy, ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, addr_oe, ovf;
  logic [7:0] row_addr;

  always #2 clk = ~clk;

  dram_refresh_ctl #(.REFI_CYC(REFI)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_busy(ref_busy), .ras_n(ras_n),
    .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n), .we_n(we_n), .oe_n(oe_n),
    .addr_oe(addr_oe), .row_addr(row_addr), .ovf(ovf)
  );

  typedef struct {
    logic [6:0] sig;
    logic [7:0] row;
    bit         use_row;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;
  int         started = 0;
  logic [7:0] model_row = 8'd0;

  // {ras, cas_hi, cas_lo, we, oe, addr_oe, busy}
  localparam logic [6:0] V_IDLE = 7'b1111100;
  localparam logic [6:0] V_PRE  = 7'b1111101;

  wire [6:0] obs = {ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, addr_oe, ref_busy};

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [6:0] s, input logic [7:0] r, input bit ur, input string t);
    exp_t e;
    e.sig = s; e.row = r; e.use_row = ur; e.tag = t;
    q.push_back(e);
  endtask

  // Monitor: one expected strobe vector per cycle.
  always @(negedge clk) begin
    exp_t e;
    if (q.size() != 0) begin
      e = q.pop_front();
      check(e.tag, 32'(obs), 32'(e.sig));
      if (e.use_row) check({e.tag, " row"}, 32'(row_addr), 32'(e.row));
    end
  end

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_gnt = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1; model_row = 8'd0; started = 0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Driver: grant one refresh and queue its expected strobe pattern.
  task automatic do_ref(input logic [1:0] m, input logic [1:0] m_late, input string tag);
    int eff;
    int lead;
    logic [6:0] v_lead, v_act;
    bit ur;
    while (!ref_req) @(negedge clk);
    mode_sel = m; ref_gnt = 1'b1;
    @(posedge clk); #1;
    ref_gnt = 1'b0; mode_sel = m_late; started++;
    eff  = (m == 2'd3) ? 0 : int'(m);
    lead = (eff == 2) ? 2 : 1;
    ur   = (eff == 1);
    case (eff)
      1:       begin v_lead = 7'b1111111; v_act = 7'b0111111; end
      2:       begin v_lead = 7'b1001001; v_act = 7'b0001001; end
      default: begin v_lead = 7'b1001101; v_act = 7'b0001101; end
    endcase
    for (int i = 0; i < lead; i++) push(v_lead, model_row, ur, tag);
    for (int i = 0; i < 3; i++)    push(v_act, model_row, ur, tag);
    for (int i = 0; i < 2; i++)    push(V_PRE, 8'd0, 1'b0, tag);
    if (ur) model_row = model_row + 8'd1;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 60000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic expq;
    apply_reset();
    @(negedge clk);
    check("R2 strobes idle after reset", 32'(obs), 32'(V_IDLE));
    check("R2 no request after reset", 32'(ref_req), 32'd0);
    check("R2 no overflow after reset", 32'(ovf), 32'd0);
    ref_gnt = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R3 stray grant ignored", 32'(obs), 32'(V_IDLE));
    end
    ref_gnt = 1'b0;
    while (!ref_req) @(negedge clk);
    check("R1 first request cycle", 32'(cyc), 32'(REFI));

    do_ref(2'd0, 2'd0, "R4 cas-before-ras");
    do_ref(2'd1, 2'd1, "R5 ras-only");
    do_ref(2'd1, 2'd1, "R6 ras-only next row");
    do_ref(2'd2, 2'd2, "R7 hidden");
    do_ref(2'd3, 2'd3, "R4 spare mode");
    do_ref(2'd1, 2'd2, "R11 ras-only held");
    do_ref(2'd2, 2'd0, "R11 hidden held");

    // Backlog drain: pending follows ticks minus starts.
    apply_reset();
    wait_cyc(5 * REFI);
    for (int k = 0; k < 20; k++) begin
      expq = ((cyc / REFI) - started) > 0;
      check("R9 request tracks backlog", 32'(ref_req), 32'(expq));
      if (!expq) break;
      do_ref(2'd0, 2'd0, "R9 drain");
    end
    check("R1 interval ticks counted", 32'(started >= 5), 32'd1);

    // Overflow boundary.
    apply_reset();
    wait_cyc(9 * REFI - 1);
    check("R10 eight held no overflow", 32'(ovf), 32'd0);
    @(negedge clk);
    check("R10 ninth sets overflow", 32'(ovf), 32'd1);
    do_ref(2'd0, 2'd0, "R10 service");
    check("R10 overflow sticky", 32'(ovf), 32'd1);
    apply_reset();
    @(negedge clk);
    check("R2 reset clears overflow", 32'(ovf), 32'd0);

    // Row counter wrap and independence from other modes.
    do_ref(2'd0, 2'd0, "R6 cbr leaves row");
    do_ref(2'd2, 2'd2, "R6 hidden leaves row");
    for (int n = 0; n < 257; n++) do_ref(2'd1, 2'd1, "R6 row wrap");
    check("R6 row after wrap", 32'(row_addr), 32'(model_row));
    check("R8 idle after last refresh", 32'(obs), 32'(V_IDLE));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule